// File: doc/BRIEF.md
# Serial-to-Parallel Word Aligner with Slip Control

The block turns a serial bit stream into 8-bit words. A fast clock samples the serial input, on its rising edges only in single-rate mode or on both edges in double-rate mode. A word clock at one eighth of the bit rate collects each group of eight bits as one parallel word. The bit that arrives first in a word lands in the most significant output bit.

Fabric logic aligns the word boundary by pulsing a slip request until a known training word appears at the output. Each accepted request moves the boundary. In single-rate mode the presented word rotates left by one place per slip. In double-rate mode the slips alternate: the first one after reset rotates left by three places, the next rotates right by one, and so on. In both modes eight slips bring a repeating 8-bit pattern back to its starting alignment.

A four-state controller in the word-clock domain accepts requests. IDLE_FWD and IDLE_BACK are the idle states, and they record whether the next double-rate slip is the left-by-three step (FWD) or the right-by-one step (BACK). HOLD_FWD and HOLD_BACK are entered for one word cycle after a request is accepted, and any request seen in that cycle is dropped. The transitions are as follows. A request in IDLE_FWD goes to HOLD_BACK in double-rate mode and to HOLD_FWD in single-rate mode. A request in IDLE_BACK goes to HOLD_FWD in double-rate mode and to HOLD_BACK in single-rate mode. HOLD_FWD always goes to IDLE_FWD, and HOLD_BACK always goes to IDLE_BACK. Without a request an idle state stays where it is.

Top module: `serial_word_aligner`

## Requirements
- R1: While reset is high the output word is 0 and the slip offset is zero. After reset the controller is in IDLE_FWD.
- R2: Single-rate mode: one bit is taken per rising fast-clock edge, and the earliest bit of a word is output bit 7. When the input repeats an 8-bit pattern, the output is a rotation of that pattern and stays constant from word to word.
- R3: Double-rate mode: one bit is taken on each fast-clock edge, so four fast cycles make one word. When the input repeats an 8-bit pattern, the output is a rotation of that pattern and stays constant.
- R4: In single-rate mode each accepted slip rotates the output word left by one bit position. For example, 00100111 becomes 01001110.
- R5: In double-rate mode accepted slips alternate between a left rotation by three and a right rotation by one, starting with left by three. For example, 10010011 becomes 10011100, then 01001110.
- R6: In either mode, eight accepted slips return the output word to its alignment before the first slip.
- R7: A request sampled at word-clock edge k leaves the output unchanged at edge k and shows the new alignment from edge k+1.
- R8: A request sampled at the edge right after an accepted one is ignored, so holding the request for two cycles moves the alignment only once.
- R9: A reset in the middle of a double-rate alternation makes the next slip a left-by-three step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Bit-rate sampling clock |
| word_clk | input | 1 | Word clock, edge-aligned to fast_clk |
| rst | input | 1 | Asynchronous active-high reset |
| ddr_mode | input | 1 | 0: single-rate sampling, 1: double-rate sampling (static outside reset) |
| ser_in | input | 1 | Serial data |
| slip_req | input | 1 | One-word-cycle slip request, sampled on word_clk |
| word_out | output | 8 | Aligned parallel word |

## Verification
The bench sends a repeating pattern and checks every alignment reached by slipping against its own rotation model, in both modes. The step directions are the main target: a design that used one step size for every double-rate slip, or rotated the wrong way, would drift from the model at the first or second slip and would not return to the start after eight slips. The bench also holds a request for two cycles, which catches a design that applies the slip twice. It resets in the middle of a double-rate alternation, which catches a design whose next step after reset is the right-by-one step. Finally it samples the cycle right after a request, which catches a design whose output changes one cycle early or more than one cycle late.

// File: rtl/swa_pkg.sv
package swa_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    // FWD: next double-rate slip rotates left by the long step; BACK: right by the short step
    typedef enum logic [1:0] {
        ST_IDLE_FWD  = 2'd0,
        ST_IDLE_BACK = 2'd1,
        ST_HOLD_FWD  = 2'd2,
        ST_HOLD_BACK = 2'd3
    } slip_state_e;

    typedef enum logic {
        MODE_SDR = 1'b0,
        MODE_DDR = 1'b1
    } rate_mode_e;
endpackage

// File: rtl/swa_serial_front.sv
module swa_serial_front #(
    parameter int WIDTH = 8
) (
    input  logic             fclk,
    input  logic             rst,
    input  logic             ddr,
    input  logic             sdata,
    output logic [WIDTH-1:0] shreg
);
    timeunit 1ns;
    timeprecision 100ps;

    logic             fall_bit;
    logic [WIDTH-1:0] sr_q;

    always_ff @(negedge fclk or posedge rst) begin
        if (rst) fall_bit <= 1'b0;
        else     fall_bit <= sdata;
    end

    // oldest bit drifts towards the MSB
    always_ff @(posedge fclk or posedge rst) begin
        if (rst)      sr_q <= '0;
        else if (ddr) sr_q <= {sr_q[WIDTH-3:0], fall_bit, sdata};
        else          sr_q <= {sr_q[WIDTH-2:0], sdata};
    end

    assign shreg = sr_q;

    a_r2_sdr_one_bit: assert property (@(posedge fclk) disable iff (rst)
        !ddr |=> (sr_q[0] == $past(sdata)) && (sr_q[WIDTH-1:1] == $past(sr_q[WIDTH-2:0])));
    a_r3_ddr_two_bits: assert property (@(posedge fclk) disable iff (rst)
        ddr |=> (sr_q[1:0] == {$past(fall_bit), $past(sdata)}) && (sr_q[WIDTH-1:2] == $past(sr_q[WIDTH-3:0])));
endmodule

// File: rtl/swa_slip_ctrl.sv
module swa_slip_ctrl
    import swa_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int LONG_STEP = 3,
    parameter int SHORT_STEP = 1,
    localparam int OFS_W    = $clog2(WIDTH)
) (
    input  logic             wclk,
    input  logic             rst,
    input  logic             ddr,
    input  logic             slip_req,
    output logic [OFS_W-1:0] ofs
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [OFS_W-1:0] ADD_SDR  = OFS_W'(1);
    localparam logic [OFS_W-1:0] ADD_LONG = OFS_W'(LONG_STEP % WIDTH);
    localparam logic [OFS_W-1:0] ADD_BACK = OFS_W'(WIDTH - (SHORT_STEP % WIDTH));

    slip_state_e      state_q, state_d;
    logic [OFS_W-1:0] ofs_q, ofs_d;
    logic             accept;

    always_ff @(posedge wclk or posedge rst) begin
        if (rst) begin
            state_q <= ST_IDLE_FWD;
            ofs_q   <= '0;
        end else begin
            state_q <= state_d;
            ofs_q   <= ofs_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ofs_d   = ofs_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE_FWD: begin
                if (slip_req) begin
                    accept = 1'b1;
                    if (ddr) begin
                        ofs_d   = ofs_q + ADD_LONG;
                        state_d = ST_HOLD_BACK;
                    end else begin
                        ofs_d   = ofs_q + ADD_SDR;
                        state_d = ST_HOLD_FWD;
                    end
                end
            end
            ST_IDLE_BACK: begin
                if (slip_req) begin
                    accept = 1'b1;
                    if (ddr) begin
                        ofs_d   = ofs_q + ADD_BACK;
                        state_d = ST_HOLD_FWD;
                    end else begin
                        ofs_d   = ofs_q + ADD_SDR;
                        state_d = ST_HOLD_BACK;
                    end
                end
            end
            ST_HOLD_FWD:  state_d = ST_IDLE_FWD;
            ST_HOLD_BACK: state_d = ST_IDLE_BACK;
            default:      state_d = ST_IDLE_FWD;
        endcase
    end

    assign ofs = ofs_q;

    a_r8_hold_ignores: assert property (@(posedge wclk) disable iff (rst)
        (state_q == ST_HOLD_FWD || state_q == ST_HOLD_BACK) |=> $stable(ofs_q));
    a_r8_hold_one_cycle: assert property (@(posedge wclk) disable iff (rst)
        accept |=> (state_q == ST_HOLD_FWD || state_q == ST_HOLD_BACK));
    a_r4_sdr_step: assert property (@(posedge wclk) disable iff (rst)
        (accept && !ddr) |=> ofs_q == OFS_W'($past(ofs_q) + OFS_W'(1)));
    a_r5_ddr_long: assert property (@(posedge wclk) disable iff (rst)
        (accept && ddr && state_q == ST_IDLE_FWD) |=> (ofs_q == OFS_W'($past(ofs_q) + ADD_LONG)) && (state_q == ST_HOLD_BACK));
    a_r5_ddr_back: assert property (@(posedge wclk) disable iff (rst)
        (accept && ddr && state_q == ST_IDLE_BACK) |=> (ofs_q == OFS_W'($past(ofs_q) - OFS_W'(SHORT_STEP))) && (state_q == ST_HOLD_FWD));
    a_r7_idle_keeps: assert property (@(posedge wclk) disable iff (rst)
        (!slip_req && (state_q == ST_IDLE_FWD || state_q == ST_IDLE_BACK)) |=> $stable(ofs_q) && $stable(state_q));
endmodule

// File: rtl/swa_word_rotator.sv
module swa_word_rotator #(
    parameter int WIDTH = 8,
    localparam int OFS_W = $clog2(WIDTH)
) (
    input  logic             wclk,
    input  logic             rst,
    input  logic [WIDTH-1:0] shreg,
    input  logic [OFS_W-1:0] ofs,
    output logic [WIDTH-1:0] word
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [WIDTH-1:0] raw_q;
    logic [WIDTH-1:0] word_q;
    logic [WIDTH-1:0] rotated;

    always_comb begin
        rotated = '0;
        for (int i = 0; i < WIDTH; i++) begin
            rotated[(i + int'(ofs)) % WIDTH] = raw_q[i];
        end
    end

    always_ff @(posedge wclk or posedge rst) begin
        if (rst) begin
            raw_q  <= '0;
            word_q <= '0;
        end else begin
            raw_q  <= shreg;
            word_q <= rotated;
        end
    end

    assign word = word_q;

    a_r2_word_steady: assert property (@(posedge wclk) disable iff (rst)
        ($stable(ofs) && $stable(raw_q)) |=> $stable(word_q));
    a_r6_zero_offset_passes: assert property (@(posedge wclk) disable iff (rst)
        (ofs == '0) |=> word_q == $past(raw_q));
endmodule

// File: rtl/serial_word_aligner.sv
module serial_word_aligner #(
    parameter int WORD_W     = 8,
    parameter int LONG_STEP  = 3,
    parameter int SHORT_STEP = 1
) (
    input  logic              fast_clk,
    input  logic              word_clk,
    input  logic              rst,
    input  logic              ddr_mode,
    input  logic              ser_in,
    input  logic              slip_req,
    output logic [WORD_W-1:0] word_out
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int OFS_W = $clog2(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic [OFS_W-1:0]  ofs;

    swa_serial_front #(.WIDTH(WORD_W)) u_front (
        .fclk  (fast_clk),
        .rst   (rst),
        .ddr   (ddr_mode),
        .sdata (ser_in),
        .shreg (shreg)
    );

    swa_slip_ctrl #(
        .WIDTH      (WORD_W),
        .LONG_STEP  (LONG_STEP),
        .SHORT_STEP (SHORT_STEP)
    ) u_ctrl (
        .wclk     (word_clk),
        .rst      (rst),
        .ddr      (ddr_mode),
        .slip_req (slip_req),
        .ofs      (ofs)
    );

    swa_word_rotator #(.WIDTH(WORD_W)) u_rot (
        .wclk  (word_clk),
        .rst   (rst),
        .shreg (shreg),
        .ofs   (ofs),
        .word  (word_out)
    );

    a_r1_reset_clear: assert property (@(posedge word_clk) rst |-> (word_out == '0) && (ofs == '0));
endmodule

// File: tb/serial_word_aligner_test.sv
module serial_word_aligner_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic       fclk = 1'b0;
    logic       wclk = 1'b0;
    logic       rst  = 1'b1;
    logic       ddr  = 1'b0;
    logic       sin  = 1'b0;
    logic       slip = 1'b0;
    logic [7:0] wout;

    logic [7:0] pat = 8'h27;
    int         bitpos = 0;
    int         errs = 0;
    int         checks = 0;
    bit         finished = 1'b0;
    logic [7:0] cur;
    logic [7:0] base;
    bit         next_long;

    serial_word_aligner uut (
        .fast_clk (fclk),
        .word_clk (wclk),
        .rst      (rst),
        .ddr_mode (ddr),
        .ser_in   (sin),
        .slip_req (slip),
        .word_out (wout)
    );

    always #2.5 fclk = ~fclk;

    always begin
        if (ddr) #10; else #20;
        wclk = ~wclk;
    end

    always begin
        if (ddr) @(fclk); else @(posedge fclk);
        #1;
        sin = pat[7 - bitpos];
        bitpos = (bitpos + 1) % 8;
    end

    function automatic logic [7:0] rotl8(logic [7:0] v, int n);
        logic [15:0] t;
        t = {v, v} << (n % 8);
        return t[15:8];
    endfunction

    function automatic bit is_rot(logic [7:0] w, logic [7:0] p);
        for (int n = 0; n < 8; n++) if (rotl8(p, n) == w) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic int step_of();
        int s;
        if (!ddr) return 1;
        s = next_long ? 3 : 7;
        next_long = !next_long;
        return s;
    endfunction

    task automatic start(bit m, logic [7:0] p);
        rst  = 1'b1;
        slip = 1'b0;
        ddr  = m;
        pat  = p;
        repeat (3) @(negedge wclk);
        chk(wout == 8'h00, "R1 reset output", wout, 8'h00);
        rst = 1'b0;
        next_long = 1'b1;
        repeat (4) @(negedge wclk);
        base = wout;
        cur  = wout;
        chk(is_rot(wout, p), m ? "R3 rotation of pattern" : "R2 rotation of pattern", wout, p);
        repeat (2) @(negedge wclk);
        chk(wout == base, m ? "R3 steady word" : "R2 steady word", wout, base);
    endtask

    task automatic slip_one(string tag);
        @(negedge wclk) slip = 1'b1;
        @(negedge wclk) slip = 1'b0;
        chk(wout == cur, "R7 unchanged at request edge", wout, cur);
        @(negedge wclk);
        cur = rotl8(cur, step_of());
        chk(wout == cur, tag, wout, cur);
    endtask

    task automatic slip_held(string tag);
        @(negedge wclk) slip = 1'b1;
        @(negedge wclk);
        @(negedge wclk) slip = 1'b0;
        cur = rotl8(cur, step_of());
        chk(wout == cur, tag, wout, cur);
        @(negedge wclk);
        chk(wout == cur, tag, wout, cur);
    endtask

    initial begin
        void'($urandom(32'd4711));

        // R4, R6: single-rate directed walk
        start(1'b0, 8'h27);
        for (int i = 0; i < 8; i++) slip_one("R4 single-rate left by one");
        chk(wout == base, "R6 single-rate wrap", wout, base);

        // R5, R6: double-rate directed walk
        start(1'b1, 8'h93);
        for (int i = 0; i < 8; i++) slip_one("R5 double-rate alternation");
        chk(wout == base, "R6 double-rate wrap", wout, base);

        // R8: held request in both modes
        start(1'b0, 8'h1D);
        slip_held("R8 held request single-rate");
        start(1'b1, 8'h1D);
        slip_held("R8 held request double-rate");
        slip_one("R8 next slip after held one is right by one");

        // R9: reset mid-alternation
        start(1'b1, 8'hB4);
        slip_one("R9 first slip left by three");
        start(1'b1, 8'hB4);
        slip_one("R9 after reset left by three again");

        // random patterns and gaps
        for (int t = 0; t < 10; t++) begin
            start(1'($urandom % 2), 8'($urandom));
            for (int i = 0; i < 8; i++) begin
                repeat ($urandom % 3) @(negedge wclk);
                slip_one(ddr ? "R5 random double-rate slip" : "R4 random single-rate slip");
            end
            chk(wout == base, "R6 random wrap", wout, base);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL R7 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule